// File: doc/BRIEF.md
# Flash Completion Poller with Timeouts

This block waits for a program or erase operation already issued to a flash part to finish. After a start pulse it reads the part's status word over a simple read port, over and over. Each read is decoded in one of two ways. In the ready-flag style, a ready bit ends the wait and a set of fault bits is ranked into one error code. In the toggle style, two reads are made back to back and the wait ends when bit 6 holds the same value in both. When the wait ends the block gives a one-cycle done pulse together with an error code.

While polling, the block compares elapsed time with two deadlines for the operation class: a typical deadline and a maximum deadline. The three classes are erase, single-word program and buffered program. Time is counted in `time_tick` pulses. Before each poll starts, the elapsed count is stored, so the last poll always looks at a time stamp taken after any deadline that has passed. Each class keeps one saturating counter for typical deadlines missed and one for maximum deadlines missed.

The deadlines are built from exponent inputs. The typical deadline is 2^typ ticks. The maximum deadline is 2^(typ+max) ticks. The exponent inputs are checked against limits before a start is accepted. A cycle limit set at build time ends a poll that never completes.

Top module: `flpoll_top`

## Requirements
- R1: Erase exponents: a typical value of 0 is taken as 16 and a maximum value of 0 is taken as 4. `cfg_ok` is low when the resulting typical value exceeds 41, or when typical plus maximum exceeds 41.
- R2: Program exponents: a typical value of 0 is taken as 18 and a maximum value of 0 is taken as 4. `cfg_ok` is low when the resulting typical value exceeds 51, or when typical plus maximum exceeds 51.
- R3: Buffered-program exponents get no default values. `cfg_ok` is low when the typical value exceeds 51, or when typical plus maximum exceeds 51. A typical value of 0 marks buffered programming as unsupported, and a start for that class ends with error code 6.
- R4: A start taken while idle ends with done on the next cycle and error code 6 (config) in any of these cases: `cfg_ok` is low, `op_class` is 3, or the class is unsupported. No status read is issued and no counter changes.
- R5: Ready-flag style (`style`=0): a poll completes when bit 7 is set. Bits 7 and 0 are then ignored and the error is ranked as follows: bit 1 gives code 1 (protect), else bit 4 gives code 2 (program), else bit 5 gives code 3 (erase), else any of bits 2, 3 or 6 gives code 4 (generic), else code 0.
- R6: In ready-flag style, a status word with bit 7 clear starts another poll, whatever its other bits are.
- R7: Toggle style (`style`=1): each poll is two consecutive reads, and the poll completes with code 0 when bit 6 matches in both reads. Other bits are ignored.
- R8: The typical-miss counter of the active class goes up by one at most once per operation. This happens on the first poll whose stored time stamp is greater than 2^typ.
- R9: The maximum-miss counter of the active class goes up by one on every poll whose stored time stamp is greater than 2^(typ+max). This applies to the completing poll as well.
- R10: When a poll ends without completion and the cycle count since start (which is 0 in the first poll cycle) is at least HARD_LIMIT, the operation ends with code 5 (timeout). Counters are 16 bits wide and stop at 65535.
- R11: `done` is high for exactly one cycle. It follows the edge at which the last read returns, so with `rd_valid` held high it appears N cycles after the start edge for an operation of N reads. `rd_req` is high only while polling. A start pulse while busy is ignored.
- R12: A synchronous reset clears all counters and returns the block to idle with `busy`, `done` and `rd_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin waiting for an operation (taken when idle) |
| op_class | input | 2 | 0 erase, 1 program, 2 buffered program, 3 invalid |
| style | input | 1 | 0 ready-flag decode, 1 toggle decode |
| time_tick | input | 1 | One pulse per time unit of elapsed time |
| erase_typ_exp | input | 8 | Erase typical exponent |
| erase_max_exp | input | 8 | Erase maximum exponent |
| write_typ_exp | input | 8 | Program typical exponent |
| write_max_exp | input | 8 | Program maximum exponent |
| bufwr_typ_exp | input | 8 | Buffered-program typical exponent |
| bufwr_max_exp | input | 8 | Buffered-program maximum exponent |
| rd_req | output | 1 | Status read request, held until `rd_valid` |
| rd_valid | input | 1 | Read data present on `rd_data` this cycle |
| rd_data | input | 8 | Status word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, valid with `done` |
| cfg_ok | output | 1 | The exponent inputs are within limits |
| tto_count | output | 48 | Typical-miss counters, 16 bits per class, erase in the low bits |
| mto_count | output | 48 | Maximum-miss counters, same layout |

## Verification
With `rd_valid` and `time_tick` held high, each read takes exactly one cycle. This means the done pulse for an operation of N reads is due at the Nth edge after the edge that takes the start, and a config rejection is due at the first edge. The time stamp of poll k equals the number of reads made before it. The driver uses this to compute the expected result code, the done cycle and all six counter values, and it pushes them into a queue before it raises start. A monitor samples on falling edges, so it sees the registered outputs after they have settled. It pops one item per done pulse and compares the cycle number and every field against that item.

// File: rtl/flpoll_pkg.sv
package flpoll_pkg;

    localparam int STAT_W   = 8;
    localparam int EXP_W    = 8;
    localparam int SHIFT_W  = 6;
    localparam int N_CLASS  = 3;

    localparam int BIT_READY   = 7;
    localparam int BIT_TOGGLE  = 6;
    localparam int BIT_ERS_ERR = 5;
    localparam int BIT_PRG_ERR = 4;
    localparam int BIT_PROT    = 1;
    localparam int BIT_RSVD    = 0;

    localparam logic [EXP_W-1:0] ERASE_TYP_DEF = 8'd16;
    localparam logic [EXP_W-1:0] WRITE_TYP_DEF = 8'd18;
    localparam logic [EXP_W-1:0] MAX_DEF       = 8'd4;
    localparam logic [EXP_W-1:0] ERASE_LIMIT   = 8'd41;
    localparam logic [EXP_W-1:0] WRITE_LIMIT   = 8'd51;

    typedef enum logic [1:0] {
        CLS_ERASE = 2'd0,
        CLS_WRITE = 2'd1,
        CLS_BUFWR = 2'd2,
        CLS_NONE  = 2'd3
    } op_class_e;

    typedef enum logic {
        STY_FLAG   = 1'b0,
        STY_TOGGLE = 1'b1
    } style_e;

    typedef enum logic [2:0] {
        ERR_OK      = 3'd0,
        ERR_PROTECT = 3'd1,
        ERR_PROGRAM = 3'd2,
        ERR_ERASE   = 3'd3,
        ERR_GENERIC = 3'd4,
        ERR_TIMEOUT = 3'd5,
        ERR_CONFIG  = 3'd6
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL_A = 2'd1,
        ST_POLL_B = 2'd2,
        ST_FIN    = 2'd3
    } state_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] typ;
        logic [SHIFT_W-1:0] tot;
        logic               ok;
        logic               supported;
    } class_cfg_t;

    // Apply optional defaults to one exponent pair and range-check it.
    function automatic class_cfg_t check_class(
        input logic [EXP_W-1:0] t_in,
        input logic [EXP_W-1:0] m_in,
        input logic [EXP_W-1:0] t_def,
        input logic [EXP_W-1:0] m_def,
        input logic [EXP_W-1:0] limit,
        input logic             apply_def
    );
        logic [EXP_W-1:0] t;
        logic [EXP_W-1:0] m;
        logic [EXP_W:0]   sum;
        class_cfg_t       r;
        t   = (apply_def && t_in == '0) ? t_def : t_in;
        m   = (apply_def && m_in == '0) ? m_def : m_in;
        sum = {1'b0, t} + {1'b0, m};
        r.ok        = (t <= limit) && (sum <= {1'b0, limit});
        r.supported = (t != '0);
        r.typ       = t[SHIFT_W-1:0];
        r.tot       = sum[SHIFT_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/flpoll_cfg.sv
module flpoll_cfg
    import flpoll_pkg::*;
(
    input  logic [EXP_W-1:0]               erase_typ_exp,
    input  logic [EXP_W-1:0]               erase_max_exp,
    input  logic [EXP_W-1:0]               write_typ_exp,
    input  logic [EXP_W-1:0]               write_max_exp,
    input  logic [EXP_W-1:0]               bufwr_typ_exp,
    input  logic [EXP_W-1:0]               bufwr_max_exp,
    output class_cfg_t [N_CLASS-1:0]       cfg_tab,
    output logic                           cfg_ok
);

    always_comb begin
        cfg_tab[CLS_ERASE] = check_class(erase_typ_exp, erase_max_exp,
                                         ERASE_TYP_DEF, MAX_DEF, ERASE_LIMIT, 1'b1);
        cfg_tab[CLS_WRITE] = check_class(write_typ_exp, write_max_exp,
                                         WRITE_TYP_DEF, MAX_DEF, WRITE_LIMIT, 1'b1);
        // Buffered programming: zero typical means "not available", no defaults.
        cfg_tab[CLS_BUFWR] = check_class(bufwr_typ_exp, bufwr_max_exp,
                                         '0, '0, WRITE_LIMIT, 1'b0);
    end

    always_comb begin
        cfg_ok = 1'b1;
        for (int c = 0; c < N_CLASS; c++) begin
            cfg_ok = cfg_ok & cfg_tab[c].ok;
        end
    end

endmodule

// File: rtl/flpoll_decode.sv
module flpoll_decode
    import flpoll_pkg::*;
(
    input  style_e             style,
    input  logic [STAT_W-1:0]  first_rd,
    input  logic [STAT_W-1:0]  cur_rd,
    output logic               complete,
    output err_e               err
);

    localparam logic [STAT_W-1:0] KEEP_MASK =
        ~((STAT_W'(1) << BIT_READY) | (STAT_W'(1) << BIT_RSVD));

    logic [STAT_W-1:0] faults;

    assign faults = cur_rd & KEEP_MASK;

    always_comb begin
        complete = 1'b0;
        err      = ERR_OK;
        if (style == STY_TOGGLE) begin
            complete = (first_rd[BIT_TOGGLE] == cur_rd[BIT_TOGGLE]);
        end else begin
            complete = cur_rd[BIT_READY];
            if (complete) begin
                if (faults[BIT_PROT])         err = ERR_PROTECT;
                else if (faults[BIT_PRG_ERR]) err = ERR_PROGRAM;
                else if (faults[BIT_ERS_ERR]) err = ERR_ERASE;
                else if (faults != '0)        err = ERR_GENERIC;
            end
        end
    end

endmodule

// File: rtl/flpoll_counters.sv
module flpoll_counters #(
    parameter int N     = 3,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       inc_typ,
    input  logic [N-1:0]       inc_max,
    output logic [N*CNT_W-1:0] typ_cnt,
    output logic [N*CNT_W-1:0] max_cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    for (genvar c = 0; c < N; c++) begin : g_cls
        logic [CNT_W-1:0] t_q;
        logic [CNT_W-1:0] m_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                t_q <= '0;
                m_q <= '0;
            end else begin
                if (inc_typ[c] && t_q != TOP) t_q <= t_q + 1'b1;
                if (inc_max[c] && m_q != TOP) m_q <= m_q + 1'b1;
            end
        end

        assign typ_cnt[c*CNT_W +: CNT_W] = t_q;
        assign max_cnt[c*CNT_W +: CNT_W] = m_q;
    end

endmodule

// File: rtl/flpoll_top.sv
module flpoll_top
    import flpoll_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int TIME_W     = 64,
    parameter int HARD_LIMIT = 1 << 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [1:0]               op_class,
    input  logic                     style,
    input  logic                     time_tick,
    input  logic [7:0]               erase_typ_exp,
    input  logic [7:0]               erase_max_exp,
    input  logic [7:0]               write_typ_exp,
    input  logic [7:0]               write_max_exp,
    input  logic [7:0]               bufwr_typ_exp,
    input  logic [7:0]               bufwr_max_exp,
    output logic                     rd_req,
    input  logic                     rd_valid,
    input  logic [7:0]               rd_data,
    output logic                     busy,
    output logic                     done,
    output logic [2:0]               err_code,
    output logic                     cfg_ok,
    output logic [3*CNT_W-1:0]       tto_count,
    output logic [3*CNT_W-1:0]       mto_count
);

    localparam int CYC_W = $clog2(HARD_LIMIT + 1) + 1;
    localparam logic [TIME_W-1:0] ONE_T = TIME_W'(1);

    state_e                    state;
    op_class_e                 cls_q;
    style_e                    sty_q;
    err_e                      err_q;
    logic [TIME_W-1:0]         elapsed;
    logic [TIME_W-1:0]         elapsed_nxt;
    logic [TIME_W-1:0]         snap;
    logic [TIME_W-1:0]         typ_dl;
    logic [TIME_W-1:0]         max_dl;
    logic [CYC_W-1:0]          cyc;
    logic                      tto_seen;
    logic [STAT_W-1:0]         first_q;

    class_cfg_t [N_CLASS-1:0]  cfg_tab;
    class_cfg_t                sel_cfg;
    op_class_e                 req_cls;
    logic                      start_ok;

    logic                      dec_complete;
    err_e                      dec_err;
    logic                      poll_end;
    logic                      past_typ;
    logic                      past_max;
    logic                      limit_hit;
    logic [N_CLASS-1:0]        cls_onehot;
    logic [N_CLASS-1:0]        inc_typ;
    logic [N_CLASS-1:0]        inc_max;

    flpoll_cfg u_cfg (
        .erase_typ_exp (erase_typ_exp),
        .erase_max_exp (erase_max_exp),
        .write_typ_exp (write_typ_exp),
        .write_max_exp (write_max_exp),
        .bufwr_typ_exp (bufwr_typ_exp),
        .bufwr_max_exp (bufwr_max_exp),
        .cfg_tab       (cfg_tab),
        .cfg_ok        (cfg_ok)
    );

    assign req_cls = op_class_e'(op_class);

    always_comb begin
        case (req_cls)
            CLS_WRITE: sel_cfg = cfg_tab[CLS_WRITE];
            CLS_BUFWR: sel_cfg = cfg_tab[CLS_BUFWR];
            default:   sel_cfg = cfg_tab[CLS_ERASE];
        endcase
    end

    assign start_ok = cfg_ok && (req_cls != CLS_NONE) && sel_cfg.supported;

    flpoll_decode u_dec (
        .style    (sty_q),
        .first_rd (first_q),
        .cur_rd   (rd_data),
        .complete (dec_complete),
        .err      (dec_err)
    );

    // Timing: the stamp of the current poll was taken before its first read.
    assign elapsed_nxt = elapsed + TIME_W'(time_tick);
    assign past_typ    = snap > typ_dl;
    assign past_max    = snap > max_dl;
    assign limit_hit   = cyc >= CYC_W'(HARD_LIMIT);
    assign poll_end    = rd_valid &&
                         ((state == ST_POLL_A && sty_q == STY_FLAG) || state == ST_POLL_B);

    assign cls_onehot  = N_CLASS'(1) << cls_q;
    assign inc_typ     = (poll_end && past_typ && !tto_seen) ? cls_onehot : '0;
    assign inc_max     = (poll_end && past_max) ? cls_onehot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cls_q    <= CLS_ERASE;
            sty_q    <= STY_FLAG;
            err_q    <= ERR_OK;
            elapsed  <= '0;
            snap     <= '0;
            typ_dl   <= '0;
            max_dl   <= '0;
            cyc      <= '0;
            tto_seen <= 1'b0;
            first_q  <= '0;
        end else begin
            if (state != ST_IDLE) begin
                elapsed <= elapsed_nxt;
                if (!(&cyc)) cyc <= cyc + 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cls_q    <= req_cls;
                        sty_q    <= style_e'(style);
                        elapsed  <= '0;
                        snap     <= '0;
                        cyc      <= '0;
                        tto_seen <= 1'b0;
                        if (!start_ok) begin
                            err_q <= ERR_CONFIG;
                            state <= ST_FIN;
                        end else begin
                            typ_dl <= ONE_T << sel_cfg.typ;
                            max_dl <= ONE_T << sel_cfg.tot;
                            state  <= ST_POLL_A;
                        end
                    end
                end
                ST_POLL_A: begin
                    if (rd_valid && sty_q == STY_TOGGLE) begin
                        first_q <= rd_data;
                        state   <= ST_POLL_B;
                    end
                end
                ST_POLL_B: ;
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase

            if (poll_end) begin
                tto_seen <= tto_seen | past_typ;
                if (dec_complete) begin
                    err_q <= dec_err;
                    state <= ST_FIN;
                end else if (limit_hit) begin
                    err_q <= ERR_TIMEOUT;
                    state <= ST_FIN;
                end else begin
                    snap  <= elapsed_nxt;
                    state <= ST_POLL_A;
                end
            end
        end
    end

    flpoll_counters #(
        .N     (N_CLASS),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_typ (inc_typ),
        .inc_max (inc_max),
        .typ_cnt (tto_count),
        .max_cnt (mto_count)
    );

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign rd_req   = (state == ST_POLL_A) || (state == ST_POLL_B);
    assign err_code = err_q;

endmodule

// File: rtl/flpoll_chk.sv
module flpoll_chk
    import flpoll_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               rd_req,
    input logic               cfg_ok,
    input logic [1:0]         op_class,
    input logic [2:0]         err_code,
    input logic [3*CNT_W-1:0] tto_count,
    input logic [3*CNT_W-1:0] mto_count
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (busy && !done)); // R11

    AST_BAD_CFG_FAST: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (!cfg_ok || op_class == 2'd3)) |=>
        (done && err_code == 3'd6)); // R4

    for (genvar c = 0; c < 3; c++) begin : g_cnt
        AST_TTO_STEP: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (tto_count[c*CNT_W +: CNT_W] == $past(tto_count[c*CNT_W +: CNT_W]) ||
                      tto_count[c*CNT_W +: CNT_W] == $past(tto_count[c*CNT_W +: CNT_W]) + 1'b1)); // R8
        AST_MTO_STEP: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (mto_count[c*CNT_W +: CNT_W] == $past(mto_count[c*CNT_W +: CNT_W]) ||
                      mto_count[c*CNT_W +: CNT_W] == $past(mto_count[c*CNT_W +: CNT_W]) + 1'b1)); // R9
    end

endmodule

bind flpoll_top flpoll_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rd_req    (rd_req),
    .cfg_ok    (cfg_ok),
    .op_class  (op_class),
    .err_code  (err_code),
    .tto_count (tto_count),
    .mto_count (mto_count)
);

// File: tb/test_flpoll_top.sv
`timescale 1ns/1ps
module test_flpoll_top;

    localparam int LIMIT = 70000;
    localparam int SAT   = 65535;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        style = 1'b0;
    logic        time_tick = 1'b1;
    logic [7:0]  e_t = 8'd2, e_m = 8'd1, w_t = 8'd1, w_m = 8'd1, b_t = 8'd1, b_m = 8'd0;
    logic        rd_req;
    logic        rd_valid = 1'b1;
    logic [7:0]  rd_data;
    logic        busy, done, cfg_ok;
    logic [2:0]  err_code;
    logic [47:0] tto_count, mto_count;

    always #2 clk = ~clk;

    flpoll_top #(.HARD_LIMIT(LIMIT)) i_flpoll_top (
        .clk(clk), .rst(rst), .start(start), .op_class(op_class), .style(style),
        .time_tick(time_tick),
        .erase_typ_exp(e_t), .erase_max_exp(e_m),
        .write_typ_exp(w_t), .write_max_exp(w_m),
        .bufwr_typ_exp(b_t), .bufwr_max_exp(b_m),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .err_code(err_code), .cfg_ok(cfg_ok),
        .tto_count(tto_count), .mto_count(mto_count)
    );

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Status script: read i returns scr[min(i, scr_n-1)].
    logic [7:0] scr [0:15];
    int         scr_n = 1;
    int         rd_cnt = 0;

    always @(posedge clk) begin
        if (start && !busy) rd_cnt <= 0;
        else if (rd_req && rd_valid) rd_cnt <= rd_cnt + 1;
    end
    assign rd_data = scr[(rd_cnt < scr_n) ? rd_cnt : scr_n - 1];

    typedef struct packed {
        logic [2:0]  err;
        logic [63:0] when;
        logic [47:0] tto;
        logic [47:0] mto;
        logic [7:0]  tag;
    } item_t;

    item_t       q[$];
    int          m_tto [0:2];
    int          m_mto [0:2];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [47:0] pack3(input int a0, input int a1, input int a2);
        return {a2[15:0], a1[15:0], a0[15:0]};
    endfunction

    // Monitor: one queue item per done pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(err_code == it.err, $sformatf("R%0d err_code", it.tag), err_code, it.err);
                chk(cyc == it.when, "R11 done cycle", cyc, it.when);
                chk(tto_count == it.tto, "R8 typical counters", tto_count, it.tto);
                chk(mto_count == it.mto, "R9 max counters", mto_count, it.mto);
            end
        end
    end

    // Driver: model counters/timing, push item, pulse start.
    task automatic run_op(input int cls, input int sty, input int last, input int exp_err,
                          input int tag, input bit poke_busy);
        int     rp;
        longint tdl, mdl, reads;
        bit     seen;
        item_t  it;
        rp = sty ? 2 : 1;
        reads = 0;
        if (exp_err != 6) begin
            case (cls)
                0: begin tdl = 64'd1 << e_t; mdl = 64'd1 << (e_t + e_m); end
                1: begin tdl = 64'd1 << w_t; mdl = 64'd1 << (w_t + w_m); end
                default: begin tdl = 64'd1 << b_t; mdl = 64'd1 << (b_t + b_m); end
            endcase
            seen = 1'b0;
            for (int k = 0; k <= last; k++) begin
                longint snap;
                snap = longint'(k) * rp;
                if (snap > tdl && !seen) begin
                    seen = 1'b1;
                    if (m_tto[cls] < SAT) m_tto[cls]++;
                end
                if (snap > mdl && m_mto[cls] < SAT) m_mto[cls]++;
            end
            reads = longint'(last + 1) * rp;
        end
        @(negedge clk);
        op_class = cls[1:0];
        style    = sty[0];
        start    = 1'b1;
        it.err  = exp_err[2:0];
        it.when = cyc + 1 + reads;
        it.tto  = pack3(m_tto[0], m_tto[1], m_tto[2]);
        it.mto  = pack3(m_mto[0], m_mto[1], m_mto[2]);
        it.tag  = tag[7:0];
        q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            // R11: a start while busy must not restart or change the operation
            op_class = 2'd0;
            style    = 1'b1;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R11 busy after ignored start", busy, 1);
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_case(input logic [7:0] et, em, wt, wm, bt, bm,
                            input bit exp_ok, input string req);
        @(negedge clk);
        e_t = et; e_m = em; w_t = wt; w_m = wm; b_t = bt; b_m = bm;
        #1;
        chk(cfg_ok == exp_ok, req, cfg_ok, exp_ok);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        chk(1'b0, "watchdog expired", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin m_tto[c] = 0; m_mto[c] = 0; end
        scr[0] = 8'h00; scr_n = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(busy == 0 && done == 0 && rd_req == 0, "R12 idle after reset", {busy, done, rd_req}, 0);
        chk(tto_count == 0 && mto_count == 0, "R12 counters zero", tto_count | mto_count, 0);

        // R5 immediate ready, no faults
        scr[0] = 8'h80; scr_n = 1;
        run_op(1, 0, 0, 0, 5, 0);

        // R6 not-ready words keep polling; R5 protect wins; R8/R9 counting
        scr[0] = 8'h12; scr[1] = 8'h32; scr[2] = 8'h00; scr[3] = 8'h3E;
        scr[4] = 8'h00; scr[5] = 8'h00; scr[6] = 8'hB2; scr_n = 7;
        run_op(1, 0, 6, 1, 6, 0);

        // R5 program beats erase; erase alone; generic; reserved bit ignored
        scr[0] = 8'hB0; scr_n = 1;
        run_op(0, 0, 0, 2, 5, 0);
        scr[0] = 8'hA0; scr_n = 1;
        run_op(2, 0, 0, 3, 5, 0);
        scr[0] = 8'h88; scr_n = 1;
        run_op(1, 0, 0, 4, 5, 0);
        scr[0] = 8'h81; scr_n = 1;
        run_op(1, 0, 0, 0, 5, 0);

        // R7 toggle: bit 6 differs for five polls, then matches
        for (int i = 0; i < 10; i++) scr[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
        scr[10] = 8'h44; scr[11] = 8'h44; scr_n = 12;
        run_op(0, 1, 5, 0, 7, 0);
        // R7 fault-looking bits ignored in toggle style
        scr[0] = 8'h32; scr_n = 1;
        run_op(2, 1, 0, 0, 7, 0);

        // R1 erase defaults and limits
        cfg_case(8'd0, 8'd25, 8'd1, 8'd1, 8'd1, 8'd0, 1'b1, "R1 erase 16+25 accepted");
        cfg_case(8'd0, 8'd26, 8'd1, 8'd1, 8'd1, 8'd0, 1'b0, "R1 erase 16+26 rejected");
        cfg_case(8'd37, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 1'b1, "R1 erase 37+4 accepted");
        cfg_case(8'd38, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 1'b0, "R1 erase 38+4 rejected");
        // R2 program defaults and limits
        cfg_case(8'd2, 8'd1, 8'd0, 8'd33, 8'd1, 8'd0, 1'b1, "R2 write 18+33 accepted");
        cfg_case(8'd2, 8'd1, 8'd0, 8'd34, 8'd1, 8'd0, 1'b0, "R2 write 18+34 rejected");
        cfg_case(8'd2, 8'd1, 8'd48, 8'd0, 8'd1, 8'd0, 1'b0, "R2 write 48+4 rejected");
        // R3 buffered: no defaults
        cfg_case(8'd2, 8'd1, 8'd1, 8'd1, 8'd0, 8'd51, 1'b1, "R3 bufwr 0+51 accepted");
        cfg_case(8'd2, 8'd1, 8'd1, 8'd1, 8'd10, 8'd42, 1'b0, "R3 bufwr 10+42 rejected");
        cfg_case(8'd2, 8'd1, 8'd1, 8'd1, 8'd51, 8'd0, 1'b1, "R3 bufwr 51+0 accepted");

        // R3 unsupported buffered class -> config error
        cfg_case(8'd2, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 1'b1, "R3 bufwr unsupported still valid");
        scr[0] = 8'h80; scr_n = 1;
        run_op(2, 0, 0, 6, 3, 0);
        // R4 invalid exponents reject a start
        cfg_case(8'd50, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 1'b0, "R4 erase 50 rejected");
        run_op(1, 0, 0, 6, 4, 0);
        // R4 invalid class
        cfg_case(8'd2, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 1'b1, "R4 baseline valid");
        run_op(3, 0, 0, 6, 4, 0);

        // R10 hard limit with saturating max counter; R11 start ignored while busy
        scr[0] = 8'h00; scr_n = 1;
        run_op(2, 0, LIMIT, 5, 10, 1);
        chk(mto_count[47:32] == 16'hFFFF, "R10 counter saturated", mto_count[47:32], SAT);

        // R12 reset clears counters
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tto_count == 0, "R12 typical counters cleared", tto_count, 0);
        chk(mto_count == 0, "R12 max counters cleared", mto_count, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule